// File: doc/BRIEF.md
# Serial ADC Readout Controller (host-driven data clock)

This block runs one convert-then-read cycle on a 12-bit sampling converter whose serial output is shifted by a clock that the host supplies. A `start` request makes the controller drop the read/convert line to start a conversion. It then keeps chip-select low and the data clock parked low while the converter reports BUSY. When BUSY returns high, the controller waits a setup interval and toggles the data clock for twelve periods. It captures the serial data line once per period, MSB first, and presents the finished word with a one-cycle strobe.

Every interval is a count of system clocks: the convert pulse, the setup time, the high and low parts of the data clock, and the sample point inside the high part. The high and low counts should be chosen so that the high share falls between 20% and 70% of the period. At least 5 system cycles of high time and 4 of low time are needed to meet the device minimums at 100 MHz. The BUSY input crosses into the system clock domain through a synchronizer of configurable depth.

Top module: `serial_adc_reader`

## Requirements
- R1: During and right after reset, chip-select is high, read/convert is high, the data clock is low, the result strobe and the busy flag are low, and the result is zero.
- R2: A `start` seen high in idle produces one cycle with read/convert low and chip-select still high. It is followed by CONV_CYC cycles with both lines low, which form the convert pulse.
- R3: After the convert pulse, read/convert returns high and chip-select stays low. The data clock stays low until the synchronized BUSY has first been seen low and then seen high. BUSY passes through SYNC_STAGES flops that reset to high.
- R4: Whenever chip-select and the BUSY input are both low, at least one of read/convert and the data clock is low.
- R5: Once the synchronized BUSY is seen high, the controller holds chip-select low, read/convert high and the data clock low for SETUP_CYC cycles before the first rising data-clock edge.
- R6: The data clock makes exactly WORD_W periods, each HIGH_CYC cycles high followed by LOW_CYC cycles low. It is high only while chip-select is low and read/convert is high.
- R7: In each period, the data line is captured at the system-clock edge that ends high cycle number SAMPLE_OFS (counting from 0). The first captured bit becomes the MSB of the result.
- R8: The cycle after the last low phase, the strobe is high for exactly one cycle and chip-select goes high. The result holds the captured word until the next completion.
- R9: The busy flag is high from the cycle after `start` is accepted through the strobe cycle. A `start` seen while the flag is high is ignored, and a `start` held high begins a new sequence straight after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one convert-and-read sequence |
| adcBusy | input | 1 | Converter BUSY, low while converting (asynchronous) |
| adcSdata | input | 1 | Converter serial data |
| adcCsN | output | 1 | Converter chip-select, active low |
| adcReadConv | output | 1 | Read/convert line: low starts a conversion, high selects output mode |
| adcDclk | output | 1 | Data clock driven to the converter |
| result | output | WORD_W | Last assembled word |
| resultValid | output | 1 | One-cycle strobe when `result` is updated |
| ctrlBusy | output | 1 | Sequence in progress |

## Verification
The checks assume the converter pulls BUSY low while the convert pulse is still running. They also assume BUSY stays low long enough to pass through the synchronizer, and stays high at all other times. They further assume the serial line settles before the sample point of each period. The stimulus drives BUSY low on the first cycle of the convert pulse and holds it low for 6 to 40 cycles. It changes the data line half a system cycle after each rising data-clock edge and inverts it after each falling edge, so a capture made at the wrong moment would pick up the inverted value. `start` is pulsed in idle, pulsed in the middle of a sequence, and held high across two sequences.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ARM,
    PH_CONVERT,
    PH_WAIT_LOW,
    PH_WAIT_HIGH,
    PH_SETUP,
    PH_CLK_HIGH,
    PH_CLK_LOW,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic clearShift;
    logic shiftBit;
    logic publish;
  } dpStrobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adcrd_sync.sv
module adcrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int CONV_CYC   = 4,
  parameter int SETUP_CYC  = 3,
  parameter int HIGH_CYC   = 5,
  parameter int LOW_CYC    = 5,
  parameter int SAMPLE_OFS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busySync,
  output logic      csN,
  output logic      rcHigh,
  output logic      dclk,
  output logic      ctrlBusy,
  output dpStrobe_t strobe
);
  localparam int TMAX  = maxOf4(CONV_CYC, SETUP_CYC, HIGH_CYC, LOW_CYC);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LAST   = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_AT  = CNT_W'(SAMPLE_OFS);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_W - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] tick, tickNext;
  logic [BIT_W-1:0] bitIdx, bitIdxNext;

  always_comb begin
    phaseNext  = phase;
    tickNext   = tick;
    bitIdxNext = bitIdx;
    strobe     = '0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phaseNext         = PH_ARM;
          strobe.clearShift = 1'b1;
        end
      end
      PH_ARM: begin
        phaseNext = PH_CONVERT;
        tickNext  = '0;
      end
      PH_CONVERT: begin
        if (tick == CONV_LAST) phaseNext = PH_WAIT_LOW;
        else                   tickNext  = tick + 1'b1;
      end
      PH_WAIT_LOW: begin
        if (!busySync) phaseNext = PH_WAIT_HIGH;
      end
      PH_WAIT_HIGH: begin
        if (busySync) begin
          phaseNext = PH_SETUP;
          tickNext  = '0;
        end
      end
      PH_SETUP: begin
        if (tick == SETUP_LAST) begin
          phaseNext  = PH_CLK_HIGH;
          tickNext   = '0;
          bitIdxNext = '0;
        end else begin
          tickNext = tick + 1'b1;
        end
      end
      PH_CLK_HIGH: begin
        if (tick == SAMPLE_AT) strobe.shiftBit = 1'b1;
        if (tick == HIGH_LAST) begin
          phaseNext = PH_CLK_LOW;
          tickNext  = '0;
        end else begin
          tickNext = tick + 1'b1;
        end
      end
      PH_CLK_LOW: begin
        if (tick == LOW_LAST) begin
          tickNext = '0;
          if (bitIdx == LAST_BIT) begin
            phaseNext      = PH_DONE;
            strobe.publish = 1'b1;
          end else begin
            bitIdxNext = bitIdx + 1'b1;
            phaseNext  = PH_CLK_HIGH;
          end
        end else begin
          tickNext = tick + 1'b1;
        end
      end
      PH_DONE:  phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      tick   <= '0;
      bitIdx <= '0;
    end else begin
      phase  <= phaseNext;
      tick   <= tickNext;
      bitIdx <= bitIdxNext;
    end
  end

  assign csN      = !(phase inside {PH_CONVERT, PH_WAIT_LOW, PH_WAIT_HIGH,
                                    PH_SETUP, PH_CLK_HIGH, PH_CLK_LOW});
  assign rcHigh   = !(phase == PH_ARM || phase == PH_CONVERT);
  assign dclk     = (phase == PH_CLK_HIGH);
  assign ctrlBusy = (phase != PH_IDLE);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBusy && start) |=> phase != PH_ARM);

  // R5
  first_rise_after_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dclk) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_CLK_LOW));

  // R3
  wait_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT_HIGH && !busySync) |=> phase == PH_WAIT_HIGH);
endmodule

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int HIGH_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdataIn,
  input  logic              dclkMon,
  output logic [WORD_W-1:0] result,
  output logic              resultValid
);
  localparam int HL_W = $clog2(HIGH_CYC + 2);

  logic [WORD_W-1:0] shiftReg;
  logic [HL_W-1:0]   highLen;

  always_ff @(posedge clk) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobe.clearShift) shiftReg <= '0;
    else if (strobe.shiftBit)   shiftReg <= {shiftReg[WORD_W-2:0], sdataIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.publish;
      if (strobe.publish) result <= shiftReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        highLen <= '0;
    else if (dclkMon) highLen <= highLen + 1'b1;
    else              highLen <= '0;
  end

  // R6
  high_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dclkMon) |-> highLen == HL_W'(HIGH_CYC));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
  import adcrd_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int CONV_CYC    = 4,
  parameter int SETUP_CYC   = 3,
  parameter int HIGH_CYC    = 5,
  parameter int LOW_CYC     = 5,
  parameter int SAMPLE_OFS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              adcBusy,
  input  logic              adcSdata,
  output logic              adcCsN,
  output logic              adcReadConv,
  output logic              adcDclk,
  output logic [WORD_W-1:0] result,
  output logic              resultValid,
  output logic              ctrlBusy
);
  localparam int RC_W = $clog2(WORD_W + 2);

  logic      busySync;
  dpStrobe_t strobe;

  adcrd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(adcBusy), .qOut(busySync)
  );

  adcrd_ctrl #(
    .WORD_W(WORD_W), .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC),
    .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC), .SAMPLE_OFS(SAMPLE_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busySync(busySync),
    .csN(adcCsN), .rcHigh(adcReadConv), .dclk(adcDclk),
    .ctrlBusy(ctrlBusy), .strobe(strobe)
  );

  adcrd_datapath #(.WORD_W(WORD_W), .HIGH_CYC(HIGH_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdataIn(adcSdata),
    .dclkMon(adcDclk), .result(result), .resultValid(resultValid)
  );

  // rising-edge tally of the data clock, used by the checks below
  logic            dclkPrev;
  logic [RC_W-1:0] riseCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dclkPrev <= 1'b0;
      riseCnt  <= '0;
    end else begin
      dclkPrev <= adcDclk;
      if (adcCsN)                   riseCnt <= '0;
      else if (adcDclk && !dclkPrev) riseCnt <= riseCnt + 1'b1;
    end
  end

  // R4
  load_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adcCsN && !adcBusy) |-> !(adcReadConv && adcDclk));

  // R6
  dclk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcDclk |-> (!adcCsN && adcReadConv));

  // R2
  rc_before_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> (!adcReadConv && $past(!adcReadConv)));

  // R6
  period_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> riseCnt == RC_W'(WORD_W));

  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!adcCsN || resultValid) |-> ctrlBusy);
endmodule

// File: tb/serial_adc_reader_test.sv
module serial_adc_reader_test;
  localparam int W     = 12;
  localparam int CONV  = 4;
  localparam int SETUP = 3;
  localparam int HIGHC = 5;
  localparam int LOWC  = 5;
  localparam int SOFS  = 3;
  localparam int SYNC  = 2;

  localparam int M_IDLE = 0, M_ARM = 1, M_CONV = 2, M_WLOW = 3, M_WHIGH = 4,
                 M_SETUP = 5, M_HIGH = 6, M_LOW = 7, M_DONE = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic adcBusy = 1'b1;
  logic adcSdata = 1'b0;
  logic adcCsN, adcReadConv, adcDclk, resultValid, ctrlBusy;
  logic [W-1:0] result;

  always #5 clk = ~clk;

  serial_adc_reader #(
    .WORD_W(W), .CONV_CYC(CONV), .SETUP_CYC(SETUP), .HIGH_CYC(HIGHC),
    .LOW_CYC(LOWC), .SAMPLE_OFS(SOFS), .SYNC_STAGES(SYNC)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .adcBusy(adcBusy), .adcSdata(adcSdata),
    .adcCsN(adcCsN), .adcReadConv(adcReadConv), .adcDclk(adcDclk),
    .result(result), .resultValid(resultValid), .ctrlBusy(ctrlBusy)
  );

  int checks = 0;
  int fails = 0;
  int validSeen = 0;
  int cycles = 0;
  bit timedOut = 1'b0;

  logic [W-1:0] devWord = '0;
  int busyLen = 10;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  int mPh = M_IDLE, mCnt = 0, mBit = 0;
  logic [W-1:0] mResult = '0;
  logic [SYNC-1:0] mSync = '1;
  logic mSeen;
  always @(posedge clk) begin
    if (!rstN) begin
      mPh = M_IDLE; mCnt = 0; mBit = 0; mResult = '0; mSync = '1;
    end else begin
      mSeen = mSync[SYNC-1];
      mSync = {mSync[SYNC-2:0], adcBusy};
      case (mPh)
        M_IDLE:  if (start) mPh = M_ARM;
        M_ARM:   begin mPh = M_CONV; mCnt = 0; end
        M_CONV:  if (mCnt == CONV - 1) mPh = M_WLOW; else mCnt++;
        M_WLOW:  if (!mSeen) mPh = M_WHIGH;
        M_WHIGH: if (mSeen) begin mPh = M_SETUP; mCnt = 0; end
        M_SETUP: if (mCnt == SETUP - 1) begin mPh = M_HIGH; mCnt = 0; mBit = 0; end
                 else mCnt++;
        M_HIGH:  if (mCnt == HIGHC - 1) begin mPh = M_LOW; mCnt = 0; end else mCnt++;
        M_LOW:   if (mCnt == LOWC - 1) begin
                   mCnt = 0;
                   if (mBit == W - 1) begin mPh = M_DONE; mResult = devWord; end
                   else begin mBit++; mPh = M_HIGH; end
                 end else mCnt++;
        default: mPh = M_IDLE;
      endcase
    end
  end

  // per-cycle comparison, then converter model updates its outputs
  logic prevDclk = 1'b0;
  int bitPos = 0;
  int busyTimer = 0;
  bit convSeen = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (rstN) begin
        string tCs, tClk;
        tCs  = (mPh == M_SETUP) ? "R5" : "R2";
        tClk = (mPh == M_WLOW || mPh == M_WHIGH) ? "R3" : "R6";
        check(adcCsN == !(mPh >= M_CONV && mPh <= M_LOW), tCs, W'(adcCsN),
              W'(!(mPh >= M_CONV && mPh <= M_LOW)));
        check(adcReadConv == !(mPh == M_ARM || mPh == M_CONV), "R2 rc",
              W'(adcReadConv), W'(!(mPh == M_ARM || mPh == M_CONV)));
        check(adcDclk == (mPh == M_HIGH), tClk, W'(adcDclk), W'(mPh == M_HIGH));
        check(ctrlBusy == (mPh != M_IDLE), "R9 busy", W'(ctrlBusy), W'(mPh != M_IDLE));
        check(resultValid == (mPh == M_DONE), "R8 strobe", W'(resultValid),
              W'(mPh == M_DONE));
        check(result == mResult, "R8 hold", result, mResult);
        check(!(!adcCsN && !adcBusy && adcReadConv && adcDclk), "R4 window",
              W'(adcDclk), W'(0));
        if (resultValid) begin
          validSeen++;
          check(result == devWord, "R7 word", result, devWord);
        end
      end
      // converter model
      if (!adcCsN && !adcReadConv && !convSeen) begin
        convSeen = 1'b1; adcBusy = 1'b0; busyTimer = busyLen;
      end else if (busyTimer > 0) begin
        busyTimer--;
        if (busyTimer == 0) adcBusy = 1'b1;
      end
      if (adcReadConv) convSeen = 1'b0;
      if (adcCsN) bitPos = 0;
      else if (adcDclk && !prevDclk) begin
        adcSdata = (bitPos < W) ? devWord[W-1-bitPos] : 1'b0;
        bitPos++;
      end else if (!adcDclk && prevDclk) adcSdata = ~adcSdata;
      prevDclk = adcDclk;
      if (cycles > 100000 && !timedOut) begin
        timedOut = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic runOne(input logic [W-1:0] word, input int blen, input bit poke);
    int target;
    devWord = word; busyLen = blen;
    target = validSeen + 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1;                  // R9: must be ignored mid-sequence
      @(negedge clk); start = 1'b0;
    end
    while (validSeen < target) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    check(adcCsN == 1'b1 && adcReadConv == 1'b1 && adcDclk == 1'b0, "R1 lines",
          W'({adcCsN, adcReadConv, adcDclk}), W'(3'b110));
    check(!resultValid && !ctrlBusy && result == '0, "R1 status", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(adcCsN && adcReadConv && !adcDclk && !ctrlBusy, "R1 after",
          W'({adcCsN, adcReadConv, adcDclk, ctrlBusy}), W'(4'b1100));
    runOne(12'hA5C, 20, 1'b0);
    runOne(12'hFFF, 6, 1'b0);
    runOne(12'h000, 25, 1'b1);
    runOne(12'h3A7, 40, 1'b0);
    // R9: start held high, two sequences back to back
    begin
      int target;
      devWord = 12'h801; busyLen = 12;
      target = validSeen + 2;
      @(negedge clk); start = 1'b1;
      while (validSeen < target) @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
    end
    check(validSeen == 6, "R8 count", W'(validSeen), W'(6));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule